// File: doc/BRIEF.md
# Flow-Through Burst SRAM with Byte-Lane Writes

This block is a synchronous static RAM whose depth is set by a parameter. Each word is 36 bits wide and is split into four 9-bit lanes. The top bit of every lane is that lane's parity bit. The block stores the parity bits and returns them on reads; it does not compute them. One bidirectional bus carries data both ways. The address and the controls are registered on the rising clock edge. Read data flows from the array straight onto the bus during the cycle in which its address was registered, with no output register in the path.

An access begins on one of two active-low start strobes. The processor-side strobe always begins a read. The controller-side strobe begins a read or a write, depending on the write controls. After the start, a two-bit burst counter produces the following addresses inside an aligned group of four words, each time the advance input is low. The group is walked either in linear order or in interleaved (XOR) order. The order is taken from a pin at the start of the burst.

Writes are decoded from three sources:
- a global write, which writes all lanes;
- a byte-write enable;
- four per-lane selects, which pick lanes when the byte-write enable is used.

An asynchronous output enable gates the bus driver. A sleep input stops all activity while the array keeps its contents.

Top module: `fthru_burst_sram`

## Requirements
- R1: The device is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 in a start cycle. A start cycle with any other combination deselects the device. While deselected, the bus is not driven and no write takes place.
- R2: When `all_wr_n`=0 in a write cycle, all four lanes are written, whatever `lane_wr_n` and `lane_sel_n` hold.
- R3: When `all_wr_n`=1 and `lane_wr_n`=0, only lane i with `lane_sel_n[i]`=0 is written. Lane i is bus bits [9i+8:9i], and bit 9i+8 is its parity bit. The other lanes keep their contents. When `all_wr_n`=1 and `lane_wr_n`=1, the cycle is a read.
- R4: A start on `proc_start_n` (with `sel_a_n`=0) ignores every write input and is a read. A write can only happen on a later beat of that burst.
- R5: Read data for the address registered at a clock edge is on the bus in the same cycle, before the next edge.
- R6: `out_en_n` acts without the clock. When it is 1 the bus is released; when it is 0 during a read cycle, the read data is driven.
- R7: The bus is not driven in the first cycle of a read that starts while the device is deselected.
- R8: Beat n of a burst starting at address A holds A's upper bits. Its low two bits are (A[1:0]+n) mod 4 in linear order (`ilv_order`=0), or A[1:0] XOR n in interleaved order (`ilv_order`=1). The order is captured at the start, so the sequence repeats every four advances.
- R9: In a burst cycle with no start, `advance_n`=0 steps the counter and `advance_n`=1 holds the address. A write on such a cycle stores to the address reached in that cycle.
- R10: While `sleep`=1, no read or write occurs and the bus is released. The array keeps its contents, and the device is deselected after `sleep` falls.
- R11: After reset, the device is deselected and the bus is released.
- R12: A start on `ctrl_start_n` that carries write controls writes the bus data to the start address at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state (the array is not reset) |
| addr | input | AW | Word address, taken on a start |
| proc_start_n | input | 1 | Processor-side start strobe, active low, always begins a read |
| ctrl_start_n | input | 1 | Controller-side start strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Primary select, active low; also qualifies the processor strobe |
| sel_b | input | 1 | Second select, active high |
| sel_c_n | input | 1 | Third select, active low |
| all_wr_n | input | 1 | Global write, active low |
| lane_wr_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| ilv_order | input | 1 | Burst order taken at a start: 1 interleaved, 0 linear |
| dq | inout | 36 | Bidirectional data bus, four 9-bit lanes |

## Verification
The write decode is walked through every one of the sixteen lane-select patterns, plus the global-write and no-write cases. Each word is written over a known old value, so that a lane written by mistake and a lane left out by mistake both show up in the read-back. Bursts are read from every start offset in both orders. The order pin is flipped in the middle of a burst, which separates an order captured at the start from one that follows the pin. A suspend beat separates a hold from a step. Release of the bus is tested by driving zero from the bench, so any driver left on by the design shows as a mismatch. Processor-strobe starts with the write controls set, deselecting combinations, and sleep with live strobes each check that nothing reaches the array.

// File: rtl/fbs_pkg.sv
`timescale 1ns/100ps
package fbs_pkg;
    localparam int LANES   = 4;
    localparam int LANE_W  = 9;
    localparam int BURST_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/fbs_seq.sv
`timescale 1ns/100ps
// Burst address sequencer: turns a start offset and a beat count into the
// low address bits for either burst order.
module fbs_seq #(
    parameter int BW = fbs_pkg::BURST_W
) (
    input  logic [BW-1:0]     start_lsb,
    input  logic [BW-1:0]     beat,
    input  fbs_pkg::order_e   order,
    output logic [BW-1:0]     lsb
);
    always_comb begin
        if (order == fbs_pkg::ORD_INTERLEAVE) begin
            lsb = start_lsb ^ beat;
        end else begin
            lsb = start_lsb + beat;
        end
    end
endmodule

// File: rtl/fbs_lane_dec.sv
`timescale 1ns/100ps
// Write decode: the global write overrides, otherwise the per-lane selects
// are used under the byte-write enable.
module fbs_lane_dec #(
    parameter int LANES = fbs_pkg::LANES
) (
    input  logic             all_wr_n,
    input  logic             lane_wr_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic [LANES-1:0] lane_en
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en[g] = !all_wr_n || (!lane_wr_n && !lane_sel_n[g]);
    end
endmodule

// File: rtl/fbs_array.sv
`timescale 1ns/100ps
// Storage split into independent lanes: one synchronous write port with a
// per-lane enable, and one asynchronous read port.
module fbs_array #(
    parameter int AW     = 6,
    parameter int LANES  = fbs_pkg::LANES,
    parameter int LANE_W = fbs_pkg::LANE_W
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [AW-1:0]           waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [AW-1:0]           raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) begin
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/fthru_burst_sram.sv
`timescale 1ns/100ps
module fthru_burst_sram #(
    parameter int AW     = 6,
    parameter int LANES  = fbs_pkg::LANES,
    parameter int LANE_W = fbs_pkg::LANE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    proc_start_n,
    input  logic                    ctrl_start_n,
    input  logic                    advance_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    all_wr_n,
    input  logic                    lane_wr_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    out_en_n,
    input  logic                    sleep,
    input  logic                    ilv_order,
    inout  wire  [LANES*LANE_W-1:0] dq
);
    localparam int DW = LANES * LANE_W;
    localparam int BW = fbs_pkg::BURST_W;

    typedef struct packed {
        logic            active;   // selected, inside an access
        fbs_pkg::order_e order;    // burst order taken at the start
        logic            mask;     // first read cycle after deselect
        logic            wr;       // the current cycle is a write
        logic [AW-1:0]   base;     // start address
        logic [BW-1:0]   cnt;      // beat count
    } ctl_t;

    ctl_t            ctl_d, ctl_q;
    logic [LANES-1:0] dec_en;
    logic [LANES-1:0] lane_we;
    logic            selected;
    logic            proc_go;
    logic            ctrl_go;
    logic [BW-1:0]   lsb_r, lsb_w;
    logic [AW-1:0]   rd_addr, wr_addr;
    logic [DW-1:0]   rd_data;
    logic            active_q;
    logic            drv_en;

    fbs_lane_dec #(.LANES(LANES)) u_dec (
        .all_wr_n   (all_wr_n),
        .lane_wr_n  (lane_wr_n),
        .lane_sel_n (lane_sel_n),
        .lane_en    (dec_en)
    );

    // Next-state computation for the access controller.
    always_comb begin
        selected = !sel_a_n && sel_b && !sel_c_n;
        proc_go  = !proc_start_n && !sel_a_n;
        ctrl_go  = !ctrl_start_n && !proc_go;
        ctl_d    = ctl_q;
        lane_we  = '0;
        if (sleep) begin
            ctl_d.active = 1'b0;
            ctl_d.wr     = 1'b0;
            ctl_d.mask   = 1'b0;
        end else if (proc_go || ctrl_go) begin
            if (selected) begin
                ctl_d.active = 1'b1;
                ctl_d.base   = addr;
                ctl_d.cnt    = '0;
                ctl_d.order  = ilv_order ? fbs_pkg::ORD_INTERLEAVE
                                         : fbs_pkg::ORD_LINEAR;
                if (ctrl_go) begin
                    lane_we = dec_en;
                end
                ctl_d.wr   = |lane_we;
                ctl_d.mask = !ctl_q.active && !(|lane_we);
            end else begin
                ctl_d.active = 1'b0;
                ctl_d.wr     = 1'b0;
                ctl_d.mask   = 1'b0;
            end
        end else if (ctl_q.active) begin
            if (!advance_n) begin
                ctl_d.cnt = ctl_q.cnt + BW'(1);
            end
            lane_we    = dec_en;
            ctl_d.wr   = |dec_en;
            ctl_d.mask = 1'b0;
        end else begin
            ctl_d.wr   = 1'b0;
            ctl_d.mask = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Address of the cycle being entered (write) and of the current cycle (read).
    fbs_seq #(.BW(BW)) u_seq_w (
        .start_lsb (ctl_d.base[BW-1:0]),
        .beat      (ctl_d.cnt),
        .order     (ctl_d.order),
        .lsb       (lsb_w)
    );

    fbs_seq #(.BW(BW)) u_seq_r (
        .start_lsb (ctl_q.base[BW-1:0]),
        .beat      (ctl_q.cnt),
        .order     (ctl_q.order),
        .lsb       (lsb_r)
    );

    assign wr_addr = {ctl_d.base[AW-1:BW], lsb_w};
    assign rd_addr = {ctl_q.base[AW-1:BW], lsb_r};

    fbs_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk   (clk),
        .we    (lane_we),
        .waddr (wr_addr),
        .wdata (dq),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign active_q = ctl_q.active;
    assign drv_en   = active_q && !ctl_q.wr && !ctl_q.mask && !out_en_n && !sleep;
    assign dq       = drv_en ? rd_data : {DW{1'bz}};
endmodule

// File: rtl/fbs_chk.sv
`timescale 1ns/100ps
module fbs_chk #(
    parameter int AW    = 6,
    parameter int LANES = fbs_pkg::LANES
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep,
    input logic             proc_start_n,
    input logic             ctrl_start_n,
    input logic             advance_n,
    input logic             sel_a_n,
    input logic             sel_b,
    input logic             sel_c_n,
    input logic             all_wr_n,
    input logic             active_q,
    input logic             drv_en,
    input logic [LANES-1:0] lane_we,
    input logic [AW-1:0]    rd_addr
);
    p_sleep_deselects_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !active_q);

    p_sleep_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (lane_we == '0));

    p_proc_start_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_start_n && !sel_a_n) |-> (lane_we == '0));

    p_global_all_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !ctrl_start_n && proc_start_n && !sel_a_n && sel_b && !sel_c_n && !all_wr_n)
        |-> (lane_we == '1));

    p_first_read_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> $past(active_q));

    p_suspend_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && proc_start_n && ctrl_start_n && advance_n && !sleep)
        |=> $stable(rd_addr));
endmodule

bind fthru_burst_sram fbs_chk #(.AW(AW), .LANES(LANES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep        (sleep),
    .proc_start_n (proc_start_n),
    .ctrl_start_n (ctrl_start_n),
    .advance_n    (advance_n),
    .sel_a_n      (sel_a_n),
    .sel_b        (sel_b),
    .sel_c_n      (sel_c_n),
    .all_wr_n     (all_wr_n),
    .active_q     (active_q),
    .drv_en       (drv_en),
    .lane_we      (lane_we),
    .rd_addr      (rd_addr)
);

// File: tb/fthru_burst_sram_tb.sv
`timescale 1ns/100ps
module fthru_burst_sram_tb;
    localparam int AW = 6;
    localparam int DW = 36;

    logic clk = 1'b0;
    logic rst_n;
    logic [AW-1:0] addr;
    logic proc_start_n, ctrl_start_n, advance_n;
    logic sel_a_n, sel_b, sel_c_n;
    logic all_wr_n, lane_wr_n;
    logic [3:0] lane_sel_n;
    logic oe_n, sleep, ilv;
    logic [DW-1:0] tb_dq;
    logic tb_drv;
    wire  [DW-1:0] dq;

    logic [DW-1:0] ref_mem [1<<AW];
    int n_chk = 0;
    int n_fail = 0;

    assign dq = tb_drv ? tb_dq : {DW{1'bz}};

    always #2.5 clk = ~clk;

    fthru_burst_sram #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .proc_start_n(proc_start_n), .ctrl_start_n(ctrl_start_n), .advance_n(advance_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
        .out_en_n(oe_n), .sleep(sleep), .ilv_order(ilv), .dq(dq)
    );

    // {all_wr_n, lane_wr_n, lane_sel_n[3:0], expected written lanes[3:0]}
    localparam logic [9:0] VEC [20] = '{
        {1'b1, 1'b0, 4'h0, 4'hF}, {1'b1, 1'b0, 4'h1, 4'hE},
        {1'b1, 1'b0, 4'h2, 4'hD}, {1'b1, 1'b0, 4'h3, 4'hC},
        {1'b1, 1'b0, 4'h4, 4'hB}, {1'b1, 1'b0, 4'h5, 4'hA},
        {1'b1, 1'b0, 4'h6, 4'h9}, {1'b1, 1'b0, 4'h7, 4'h8},
        {1'b1, 1'b0, 4'h8, 4'h7}, {1'b1, 1'b0, 4'h9, 4'h6},
        {1'b1, 1'b0, 4'hA, 4'h5}, {1'b1, 1'b0, 4'hB, 4'h4},
        {1'b1, 1'b0, 4'hC, 4'h3}, {1'b1, 1'b0, 4'hD, 4'h2},
        {1'b1, 1'b0, 4'hE, 4'h1}, {1'b1, 1'b0, 4'hF, 4'h0},
        {1'b0, 1'b1, 4'hF, 4'hF}, {1'b0, 1'b0, 4'h6, 4'hF},
        {1'b0, 1'b1, 4'h0, 4'hF}, {1'b1, 1'b1, 4'h0, 4'h0}
    };

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                            logic [3:0] lanes);
        logic [DW-1:0] r;
        r = old_w;
        for (int k = 0; k < 4; k++) begin
            if (lanes[k]) r[k*9 +: 9] = new_w[k*9 +: 9];
        end
        return r;
    endfunction

    function automatic logic [AW-1:0] baddr(logic [AW-1:0] st, int n, bit il);
        logic [1:0] l;
        l = il ? (st[1:0] ^ 2'(n)) : (st[1:0] + 2'(n));
        return {st[AW-1:2], l};
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        proc_start_n = 1'b1; ctrl_start_n = 1'b1; advance_n = 1'b1;
        all_wr_n = 1'b1; lane_wr_n = 1'b1; lane_sel_n = 4'hF;
        tb_drv = 1'b0; oe_n = 1'b0;
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    endtask

    task automatic edge1();
        @(posedge clk);
        #1;
        go_idle();
        #1;
    endtask

    // Bus released: the bench drives zero and expects to see zero.
    task automatic probe_hiz(input string req);
        tb_dq = '0;
        tb_drv = 1'b1;
        #1;
        chk(req, dq, '0);
        tb_drv = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [AW-1:0] a, input logic gw_n, input logic bwe_n,
                           input logic [3:0] bw_n, input logic [DW-1:0] d);
        addr = a; ctrl_start_n = 1'b0;
        all_wr_n = gw_n; lane_wr_n = bwe_n; lane_sel_n = bw_n;
        oe_n = 1'b1; tb_dq = d; tb_drv = 1'b1;
        edge1();
    endtask

    task automatic rd_ctrl(input logic [AW-1:0] a);
        addr = a; ctrl_start_n = 1'b0;
        edge1();
    endtask

    task automatic beat_wr(input bit adv, input logic [DW-1:0] d);
        advance_n = !adv; all_wr_n = 1'b0; oe_n = 1'b1; tb_dq = d; tb_drv = 1'b1;
        edge1();
    endtask

    // R8: walk a whole burst, flip the order pin mid-way, then suspend.
    task automatic burst_chk(input logic [AW-1:0] st, input bit il);
        ilv = il;
        rd_ctrl(st);
        chk("R8 R5 beat0", dq, ref_mem[baddr(st, 0, il)]);
        for (int n = 1; n <= 4; n++) begin
            advance_n = 1'b0;
            if (n == 2) ilv = !il;
            edge1();
            chk("R8 beat", dq, ref_mem[baddr(st, n, il)]);
        end
        edge1();
        chk("R9 suspend hold", dq, ref_mem[baddr(st, 4, il)]);
        ilv = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R11 watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] old_w, new_w;
        rst_n = 1'b0; sleep = 1'b0; ilv = 1'b0; addr = '0; tb_dq = '0;
        go_idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        probe_hiz("R11 bus after reset");

        // Lane decode table (R2, R3, R12), each word written over a known old value.
        for (int i = 0; i < 20; i++) begin
            old_w = {4{9'h1A5}} ^ DW'(i * 7 + 1);
            new_w = {4{9'h05A}} + DW'(i * 3 + 2);
            wr_ctrl(AW'(i), 1'b0, 1'b1, 4'hF, old_w);
            ref_mem[i] = old_w;
            wr_ctrl(AW'(i), VEC[i][9], VEC[i][8], VEC[i][7:4], new_w);
            ref_mem[i] = merge(old_w, new_w, VEC[i][3:0]);
            rd_ctrl(AW'(i));
            if (!VEC[i][9]) chk("R2 R12 global write", dq, ref_mem[i]);
            else            chk("R3 R12 lane write", dq, ref_mem[i]);
        end

        // R5: back-to-back reads of different words show the new word at once.
        rd_ctrl(6'd3);
        rd_ctrl(6'd17);
        chk("R5 flow-through", dq, ref_mem[17]);

        // R6: the output enable acts between clock edges.
        oe_n = 1'b1;
        probe_hiz("R6 oe high releases");
        oe_n = 1'b0;
        #1;
        chk("R6 oe low drives", dq, ref_mem[17]);

        // Burst reads over a filled group, every offset and both orders.
        for (int k = 0; k < 4; k++) begin
            wr_ctrl(AW'(32 + k), 1'b0, 1'b1, 4'hF, 36'h3_0000_0000 + DW'(k * 36'h1_1111) + 36'h101);
            ref_mem[32 + k] = 36'h3_0000_0000 + DW'(k * 36'h1_1111) + 36'h101;
        end
        for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < 4; s++) begin
                burst_chk(AW'(32 + s), o[0]);
            end
        end

        // R9: interleaved write burst from offset 1, then read back.
        ilv = 1'b1;
        wr_ctrl(6'd41, 1'b0, 1'b1, 4'hF, 36'h9_ABCD_0001);
        ref_mem[baddr(6'd41, 0, 1'b1)] = 36'h9_ABCD_0001;
        for (int n = 1; n < 4; n++) begin
            beat_wr(1'b1, 36'h9_ABCD_0001 + DW'(n * 36'h100));
            ref_mem[baddr(6'd41, n, 1'b1)] = 36'h9_ABCD_0001 + DW'(n * 36'h100);
        end
        ilv = 1'b0;
        burst_chk(6'd40, 1'b0);
        burst_chk(6'd41, 1'b1);

        // R4: processor-strobe start with the write controls set stays a read.
        wr_ctrl(6'd44, 1'b0, 1'b1, 4'hF, 36'h4_4444_4444);
        ref_mem[44] = 36'h4_4444_4444;
        addr = 6'd44; proc_start_n = 1'b0; all_wr_n = 1'b0;
        oe_n = 1'b1; tb_dq = 36'hB_BBBB_BBBB; tb_drv = 1'b1;
        edge1();
        chk("R4 start ignores write", dq, ref_mem[44]);
        beat_wr(1'b0, 36'hB_BBBB_BBBB);
        ref_mem[44] = 36'hB_BBBB_BBBB;
        rd_ctrl(6'd44);
        chk("R4 later beat writes", dq, ref_mem[44]);

        // R1: each deselecting combination blocks the write and releases the bus.
        wr_ctrl(6'd50, 1'b0, 1'b1, 4'hF, 36'h5_0505_0505);
        ref_mem[50] = 36'h5_0505_0505;
        for (int c = 0; c < 3; c++) begin
            sel_a_n = (c == 0); sel_b = (c != 1); sel_c_n = (c == 2);
            wr_ctrl(6'd50, 1'b0, 1'b1, 4'hF, 36'hD_EAD0_0000 + DW'(c));
            probe_hiz("R1 deselected bus");
            rd_ctrl(6'd50);
            probe_hiz("R7 first read after deselect");
            rd_ctrl(6'd50);
            chk("R1 no write while deselected", dq, ref_mem[50]);
        end

        // R10: sleep blocks access, keeps contents, and leaves the device deselected.
        wr_ctrl(6'd52, 1'b0, 1'b1, 4'hF, 36'h7_5252_5252);
        ref_mem[52] = 36'h7_5252_5252;
        sel_b = 1'b0;
        rd_ctrl(6'd0);
        sleep = 1'b1;
        wr_ctrl(6'd52, 1'b0, 1'b1, 4'hF, 36'h0_DEAD_BEEF);
        probe_hiz("R10 bus in sleep");
        rd_ctrl(6'd52);
        probe_hiz("R10 no read in sleep");
        sleep = 1'b0;
        edge1();
        rd_ctrl(6'd52);
        probe_hiz("R7 read after sleep masked");
        rd_ctrl(6'd52);
        chk("R10 contents retained", dq, ref_mem[52]);
        sleep = 1'b1;
        #1;
        probe_hiz("R10 sleep releases bus");
        edge1();
        sleep = 1'b0;
        edge1();
        probe_hiz("R10 deselected after sleep");

        summary();
        $finish;
    end
endmodule